// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block controls an external analog-to-digital converter across eight monitored channels. A host writes a 16-bit option register that selects the scan mode, starts a scan and enables individual channels. The sequencer visits the enabled channels in ascending index order. For each channel it raises a conversion request with the channel number and waits for the converter's done pulse. It then stores the returned 8-bit code in that channel's result register, which the host reads through a small index/data port.

Two scan modes are available. A one-shot scan runs once, and the start bit then clears itself. A repeating scan launches at once and then once every period. The period is counted by an internal prescaler whose length is a parameter: one second of a 200 MHz clock by default, and much shorter in simulation. A low-power input blocks new conversions. If the low-power input rises, or the host clears start during a scan, the channel being converted is allowed to finish and the scan then stops.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the option register reads 0x2000, every result register reads 0, `conv_req` is low and `scan_done` is low.
- R2: A host write loads all 16 bits of the option register, and the value reads back unchanged on the next cycle. Bits 12..8 are plain storage: writing them without bit 14 set starts no conversion.
- R3: With bit 15 = 0 (one-shot), setting bit 14 (start) runs exactly one scan. When the last enabled channel is stored, bit 14 returns to 0 and `scan_done` is high for exactly one cycle.
- R4: Enable bit i (bits 7..0) selects channel i. Enabled channels are requested in ascending index order with `conv_chan` = i, and the code returned for channel i is what result index i then reads.
- R5: Disabled channels are never requested, and their result registers keep their previous contents.
- R6: A one-shot start with bits 7..0 all zero issues no request, pulses `scan_done` once and clears bit 14.
- R7: With bit 15 = 1 (repeating), bit 14 stays set. One scan launches immediately and one more every PERIOD_CYC cycles, until bit 14 is cleared.
- R8: While `lp_mode` is high, no conversion request is started, and a pending start bit is held until `lp_mode` falls.
- R9: If bit 14 is cleared or `lp_mode` rises during a scan, the channel in progress completes and is stored. No further channel is requested and no `scan_done` is raised for that scan.
- R10: `conv_req` stays high with a stable `conv_chan` until `conv_done` is seen. It is then low for at least one cycle. A `conv_done` that arrives while `conv_req` is low changes no result.
- R11: Any converter latency of one or more cycles per channel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_we | input | 1 | Host write strobe for the option register |
| opt_wdata | input | 16 | Host write data |
| opt_rdata | output | 16 | Current option register contents |
| res_idx | input | 3 | Channel index for result read |
| res_code | output | 8 | Result register contents for `res_idx` |
| lp_mode | input | 1 | Low-power mode; blocks new conversions |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 3 | Channel being converted |
| conv_done | input | 1 | One-cycle completion pulse from converter |
| conv_data | input | 8 | Code returned with `conv_done` |
| scan_done | output | 1 | One-cycle pulse at the end of a completed scan |

## Verification
The assertions take for granted that the converter raises `conv_done` only as a single-cycle pulse answering a request, and that PERIOD_CYC is at least 2, so that period ticks cannot fall on adjacent cycles. The bench models the converter as a process that answers each rising request once, after a programmable latency, and drops the done pulse before the next request. The only deliberate exception is one stray done pulse driven while the block is idle, whose effect is checked at the result port. Host writes, result reads and `lp_mode` changes are all applied on falling edges, away from the sampling edge.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int NCH    = 8;
    localparam int CODE_W = 8;
    localparam int OPT_W  = 16;
    localparam int CH_W   = $clog2(NCH);
    localparam int RSV_W  = OPT_W - 3 - NCH;

    // Option register layout, most significant field first.
    typedef struct packed {
        logic              cont;       // 1: repeating scan
        logic              start;      // run request, self-clears in one-shot
        logic              fullscale;  // range select, stored only
        logic [RSV_W-1:0]  rsvd;       // storage only
        logic [NCH-1:0]    en;         // per-channel enables
    } opt_t;

    localparam logic [OPT_W-1:0] OPT_RESET = 16'h2000;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_CONV  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic              we;
        logic [CH_W-1:0]   idx;
        logic [CODE_W-1:0] code;
    } res_wr_t;

    // Lowest set bit of mask at index lo or above.
    function automatic pick_t pick_from(input logic [NCH-1:0] mask, input int lo);
        pick_t r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= lo)) begin
                r.hit = 1'b1;
                r.idx = CH_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_scan_optreg.sv
module adc_scan_optreg
    import adc_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OPT_W-1:0] wr_data,
    input  logic             clr_start,
    output opt_t             q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= opt_t'(OPT_RESET);
        end else if (wr_en) begin
            q <= opt_t'(wr_data);      // host write wins over self-clear
        end else if (clr_start) begin
            q.start <= 1'b0;
        end
    end

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == opt_t'($past(wr_data))));

endmodule

// File: rtl/adc_scan_tick.sv
module adc_scan_tick #(
    parameter int unsigned PERIOD = 200_000_000   // must be >= 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/adc_scan_engine.sv
module adc_scan_engine
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cont,
    input  logic              start,
    input  logic [NCH-1:0]    en,
    input  logic              lp,
    input  logic              tick,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_data,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    output logic              clr_start,
    output logic              scan_done,
    output logic              restart,
    output logic              run,
    output res_wr_t           res_wr
);

    seq_state_e      state_q;
    logic [CH_W-1:0] chan_q;
    logic [NCH-1:0]  mask_q;
    logic            armed_q;
    logic            pend_q;
    logic            done_q;

    logic  go_ok;
    logic  launch;
    logic  fin;
    logic  empty;
    pick_t first;
    pick_t nxt;

    assign go_ok  = start && !lp;
    assign first  = pick_from(en, 0);
    assign nxt    = pick_from(mask_q, int'(chan_q) + 1);
    assign launch = (state_q == SQ_IDLE) && go_ok &&
                    (!cont || !armed_q || pend_q || tick);
    assign empty  = launch && !first.hit;
    assign fin    = (state_q == SQ_CONV) && conv_done && go_ok && !nxt.hit;

    assign clr_start = (fin || empty) && !cont;
    assign restart   = launch;
    assign run       = cont && start && !lp && armed_q;

    assign conv_req  = (state_q == SQ_CONV);
    assign conv_chan = chan_q;
    assign scan_done = done_q;

    always_comb begin
        res_wr.we   = (state_q == SQ_CONV) && conv_done;
        res_wr.idx  = chan_q;
        res_wr.code = conv_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            chan_q  <= '0;
            mask_q  <= '0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fin || empty;

            if (!start || !cont) begin
                armed_q <= 1'b0;
            end else if (launch) begin
                armed_q <= 1'b1;
            end

            if (launch || !run) begin
                pend_q <= 1'b0;
            end else if (tick) begin
                pend_q <= 1'b1;
            end

            unique case (state_q)
                SQ_IDLE: begin
                    if (launch) begin
                        mask_q <= en;
                        if (first.hit) begin
                            chan_q  <= first.idx;
                            state_q <= SQ_SETUP;
                        end
                    end
                end
                SQ_SETUP: begin
                    state_q <= go_ok ? SQ_CONV : SQ_IDLE;
                end
                SQ_CONV: begin
                    if (conv_done) begin
                        if (go_ok && nxt.hit) begin
                            chan_q  <= nxt.idx;
                            state_q <= SQ_SETUP;
                        end else begin
                            state_q <= SQ_IDLE;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));

    // R10
    req_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_done) |=> !conv_req);

    // R8
    lp_block_chk: assert property (@(posedge clk) disable iff (rst)
        (lp && !conv_req) |=> !conv_req);

    // R5
    req_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> mask_q[conv_chan]);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done);

endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  res_wr_t           wr,
    input  logic [CH_W-1:0]   rd_idx,
    output logic [CODE_W-1:0] rd_code
);

    logic [NCH-1:0][CODE_W-1:0] bank;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CODE_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (wr.we && (wr.idx == CH_W'(g))) begin
                r_q <= wr.code;
            end
        end
        assign bank[g] = r_q;
    end

    assign rd_code = bank[rd_idx];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 200_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              opt_we,
    input  logic [OPT_W-1:0]  opt_wdata,
    output logic [OPT_W-1:0]  opt_rdata,
    input  logic [CH_W-1:0]   res_idx,
    output logic [CODE_W-1:0] res_code,
    input  logic              lp_mode,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_data,
    output logic              scan_done
);

    opt_t    opt_q;
    logic    clr_start;
    logic    tick;
    logic    restart;
    logic    run;
    res_wr_t res_wr;

    assign opt_rdata = opt_q;

    adc_scan_optreg u_optreg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (opt_we),
        .wr_data   (opt_wdata),
        .clr_start (clr_start),
        .q         (opt_q)
    );

    adc_scan_tick #(.PERIOD(PERIOD_CYC)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .tick    (tick)
    );

    adc_scan_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .cont      (opt_q.cont),
        .start     (opt_q.start),
        .en        (opt_q.en),
        .lp        (lp_mode),
        .tick      (tick),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .conv_req  (conv_req),
        .conv_chan (conv_chan),
        .clr_start (clr_start),
        .scan_done (scan_done),
        .restart   (restart),
        .run       (run),
        .res_wr    (res_wr)
    );

    adc_scan_results u_results (
        .clk     (clk),
        .rst     (rst),
        .wr      (res_wr),
        .rd_idx  (res_idx),
        .rd_code (res_code)
    );

endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;

    localparam int unsigned PER = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        opt_we = 1'b0;
    logic [15:0] opt_wdata = '0;
    logic [15:0] opt_rdata;
    logic [2:0]  res_idx = '0;
    logic [7:0]  res_code;
    logic        lp_mode = 1'b0;
    logic        conv_req;
    logic [2:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [7:0]  conv_data = '0;
    logic        scan_done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int rec_n = 0;
    int rec_ch [64];
    int lat = 3;
    logic [7:0] code_base = 8'h00;
    bit conv_en = 1'b1;

    always #2.5 clk = ~clk;

    adc_scan_seq #(.PERIOD_CYC(PER)) u_dut (
        .clk(clk), .rst(rst), .opt_we(opt_we), .opt_wdata(opt_wdata),
        .opt_rdata(opt_rdata), .res_idx(res_idx), .res_code(res_code),
        .lp_mode(lp_mode), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .scan_done(scan_done)
    );

    // converter model
    initial begin
        forever begin
            @(negedge clk);
            if (conv_en && !rst && conv_req) begin
                if (rec_n < 64) rec_ch[rec_n] = int'(conv_chan);
                rec_n++;
                repeat (lat) @(negedge clk);
                conv_data = code_base + {5'b0, conv_chan};
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    always @(negedge clk) if (!rst && scan_done) done_cnt++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_opt(input logic [15:0] v);
        @(negedge clk);
        opt_we = 1'b1;
        opt_wdata = v;
        @(negedge clk);
        opt_we = 1'b0;
    endtask

    task automatic rd_res(input int ch, output int v);
        @(negedge clk);
        res_idx = 3'(ch);
        #1 v = int'(res_code);
    endtask

    task automatic wait_done(input int max);
        int base = done_cnt;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (done_cnt > base) break;
        end
    endtask

    task automatic wait_req_chan(input int ch);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (conv_req && int'(conv_chan) == ch) break;
        end
    endtask

    task automatic clear_logs();
        rec_n = 0;
        done_cnt = 0;
    endtask

    task automatic t_reset();
        int v;
        chk("R1", "opt after reset", int'(opt_rdata), 16'h2000);
        chk("R1", "conv_req after reset", int'(conv_req), 0);
        chk("R1", "scan_done after reset", int'(scan_done), 0);
        for (int c = 0; c < 8; c++) begin
            rd_res(c, v);
            chk("R1", "result after reset", v, 0);
        end
    endtask

    task automatic t_regs();
        clear_logs();
        wr_opt(16'h9F5A);
        #1 chk("R2", "readback", int'(opt_rdata), 16'h9F5A);
        repeat (40) @(negedge clk);
        chk("R2", "no request without start", rec_n, 0);
        chk("R2", "no done without start", done_cnt, 0);
        wr_opt(16'h2000);
        #1 chk("R2", "readback restore", int'(opt_rdata), 16'h2000);
    endtask

    task automatic t_oneshot();
        int v;
        clear_logs();
        lat = 3;
        code_base = 8'h10;
        wr_opt(16'h40A5);
        wait_done(500);
        repeat (5) @(negedge clk);
        chk("R4", "request count", rec_n, 4);
        chk("R4", "order 1st", rec_ch[0], 0);
        chk("R4", "order 2nd", rec_ch[1], 2);
        chk("R4", "order 3rd", rec_ch[2], 5);
        chk("R4", "order 4th", rec_ch[3], 7);
        chk("R3", "done pulse cycles", done_cnt, 1);
        chk("R3", "start self-cleared", int'(opt_rdata), 16'h00A5);
        rd_res(0, v); chk("R4", "res ch0", v, 8'h10);
        rd_res(5, v); chk("R4", "res ch5", v, 8'h15);
        rd_res(7, v); chk("R4", "res ch7", v, 8'h17);
        rd_res(1, v); chk("R5", "disabled ch1 untouched", v, 0);
    endtask

    task automatic t_skip();
        int v;
        clear_logs();
        lat = 37;
        code_base = 8'h50;
        wr_opt(16'h4012);
        wait_done(1000);
        repeat (3) @(negedge clk);
        chk("R11", "long latency done", done_cnt, 1);
        chk("R5", "only enabled requested", rec_n, 2);
        rd_res(1, v); chk("R11", "res ch1", v, 8'h51);
        rd_res(4, v); chk("R11", "res ch4", v, 8'h54);
        rd_res(0, v); chk("R5", "ch0 retained", v, 8'h10);
        rd_res(2, v); chk("R5", "ch2 retained", v, 8'h12);
    endtask

    task automatic t_empty();
        clear_logs();
        lat = 3;
        wr_opt(16'h4000);
        repeat (10) @(negedge clk);
        chk("R6", "done pulses", done_cnt, 1);
        chk("R6", "no requests", rec_n, 0);
        chk("R6", "start cleared", int'(opt_rdata), 16'h0000);
    endtask

    task automatic t_idle_done();
        int v;
        conv_en = 1'b0;
        @(negedge clk);
        conv_data = 8'hFF;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        conv_en = 1'b1;
        rd_res(1, v); chk("R10", "stray done ignored ch1", v, 8'h51);
        rd_res(0, v); chk("R10", "stray done ignored ch0", v, 8'h10);
    endtask

    task automatic t_lp_block();
        int v;
        clear_logs();
        lat = 2;
        code_base = 8'h80;
        lp_mode = 1'b1;
        wr_opt(16'h40FF);
        repeat (60) @(negedge clk);
        chk("R8", "no request in low power", rec_n, 0);
        chk("R8", "start held", int'(opt_rdata), 16'h40FF);
        lp_mode = 1'b0;
        wait_done(1000);
        repeat (3) @(negedge clk);
        chk("R8", "scan after low power", rec_n, 8);
        chk("R4", "last channel order", rec_ch[7], 7);
        chk("R3", "start cleared after full scan", int'(opt_rdata), 16'h00FF);
        rd_res(7, v); chk("R4", "res ch7", v, 8'h87);
    endtask

    task automatic t_cont();
        clear_logs();
        lat = 3;
        wr_opt(16'hC003);
        repeat (1000) @(negedge clk);
        chk("R7", "scans in 1000 cycles", done_cnt, 3);
        chk("R7", "requests in 1000 cycles", rec_n, 6);
        chk("R7", "start stays set", int'(opt_rdata), 16'hC003);
        wr_opt(16'h8003);
        repeat (500) @(negedge clk);
        chk("R7", "no scan after stop", done_cnt, 3);
    endtask

    task automatic t_stop_start();
        int v;
        clear_logs();
        lat = 20;
        code_base = 8'hA0;
        wr_opt(16'hC0FF);
        wait_req_chan(2);
        wr_opt(16'h80FF);
        repeat (200) @(negedge clk);
        chk("R9", "requests up to ch2", rec_n, 3);
        chk("R9", "no done on stop", done_cnt, 0);
        rd_res(2, v); chk("R9", "ch2 finished", v, 8'hA2);
        rd_res(3, v); chk("R9", "ch3 retained", v, 8'h83);
    endtask

    task automatic t_stop_lp();
        int v;
        clear_logs();
        lat = 20;
        code_base = 8'hC0;
        wr_opt(16'h40FF);
        wait_req_chan(3);
        lp_mode = 1'b1;
        repeat (200) @(negedge clk);
        chk("R9", "requests up to ch3", rec_n, 4);
        chk("R9", "no done on low power", done_cnt, 0);
        chk("R9", "start kept", int'(opt_rdata), 16'h40FF);
        rd_res(3, v); chk("R9", "ch3 finished", v, 8'hC3);
        rd_res(4, v); chk("R9", "ch4 retained", v, 8'h84);
        lp_mode = 1'b0;
        wait_done(2000);
        repeat (3) @(negedge clk);
        chk("R9", "rerun completes", done_cnt, 1);
        chk("R9", "rerun requests", rec_n, 12);
        chk("R3", "start cleared after rerun", int'(opt_rdata), 16'h00FF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_oneshot();
        t_skip();
        t_empty();
        t_idle_done();
        t_lp_block();
        t_cont();
        t_stop_start();
        t_stop_lp();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule